// File: doc/BRIEF.md
# Clause-22 Management Interface Master

This block is a management-interface master for external Ethernet PHYs. It produces the MDC management clock from the system clock and shifts clause-22 read and write frames out on MDIO. It turns around the data line for reads and gathers the value the PHY returns. A host drives the block through two writable registers. The access register is command, status and result at the same time: the host writes it with the go bit set, polls that bit until it clears, and then takes read data from its low half. The control register turns the block on and sets the MDC divider. A third, read-only word has one bit per PHY address and shows which addresses answered their most recent read.

Internally a divider module produces the MDC pin together with one-cycle rise and fall strobes. A frame engine built around a state machine moves through the states ST_IDLE, ST_PREAMBLE, ST_HEADER, ST_TURN, ST_DATA and ST_FINISH. Every move except the first happens on a fall strobe, when the next bit is put on the line:

- ST_IDLE to ST_PREAMBLE is taken when a go is accepted.
- ST_PREAMBLE to ST_HEADER is taken after preamble bit 31.
- ST_HEADER to ST_TURN is taken after the last register-address bit, frame bit 45.
- ST_TURN to ST_DATA is taken after frame bit 47.
- ST_DATA to ST_FINISH is taken after frame bit 63.
- ST_FINISH to ST_IDLE is taken on the next fall strobe. That strobe releases the line and ends the transaction.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: When the block is enabled and not busy, a write to the access register (reg_sel=0) with bit 31 set starts a transaction. From the next clock, bit 31 of access_q reads 1 and the idle flag (control_q bit 31) reads 0. Both return to their resting values when the frame is complete.
- R2: A write transaction (bit 30 = 1) puts 64 bits on MDIO, MSB first, with the output enabled for every bit: 32 ones, start 01, opcode 01, the 5-bit PHY address from bits 20:16, the 5-bit register address from bits 25:21, turnaround 10, then the 16 data bits from bits 15:0.
- R3: A read transaction (bit 30 = 0) sends the same first 46 bits with opcode 10. The output enable is then low for the two turnaround bits and all 16 data bits.
- R4: When a read ends, access_q bits 15:0 hold the 16 bits sampled from mdio_i, MSB first. Bits 30:16 keep the values that were written.
- R5: On a read, alive_q bit [PHY address] is set if mdio_i is low in the second turnaround bit and cleared if it is high. Write transactions leave alive_q unchanged.
- R6: While enabled, MDC has a period of 2×(div+1) system clocks, high for div+1 and low for div+1, where div is control bits 7:0.
- R7: mdio_o and mdio_oe change only on clock edges where MDC falls. mdio_i is sampled on the edge where MDC rises.
- R8: A write to the access register while bit 31 reads 1 is ignored. The frame in flight and the stored fields are unaffected.
- R9: With control bit 30 clear the block is disabled: MDC stays low, and a write with the go bit set leaves bit 31 at 0.
- R10: The control register carries enable in bit 30, the read-only idle flag in bit 31 and the divider in bits 7:0. After reset, access_q and alive_q are 0, control_q is 32'h8000_0000, and MDC and mdio_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 access, 1 control |
| reg_wdata | input | 32 | Register write data |
| access_q | output | 32 | Access register: go/busy, write flag, register address, PHY address, data |
| control_q | output | 32 | Control register: idle flag, enable, divider |
| alive_q | output | 32 | One bit per PHY address that answered its last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest situation to reach is the read turnaround. The answer there depends on what the external device drives on mdio_i in one particular MDC low phase, which is long after the go write and shifted by the divider. The bench contains a small PHY model. It counts MDC rises only once the block has begun driving, and on each MDC fall it drives the value for the next frame bit index. It can therefore pull the second turnaround bit low and return chosen data, or stay silent like a missing device. A read to an address that answered before, but is now absent, shows that the alive bit is cleared as well as set.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_W  = 5;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;
    localparam int PHY_N  = 1 << PHY_W;

    localparam logic SEL_ACCESS  = 1'b0;
    localparam logic SEL_CONTROL = 1'b1;

    localparam int ACC_GO_BIT = 31;
    localparam int ACC_WR_BIT = 30;
    localparam int ACC_REG_LO = 21;
    localparam int ACC_PHY_LO = 16;
    localparam int CTL_EN_BIT = 30;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA,
        ST_FINISH
    } mdio_state_e;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             half_done;

    assign half_done = (cnt_q >= div);
    assign rise_tick = en && half_done && !mdc;
    assign fall_tick = en && half_done && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (half_done) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_wr,
    input  logic [PHY_W-1:0]  cmd_phy,
    input  logic [REG_W-1:0]  cmd_reg,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              idle,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              alive_upd,
    output logic              alive_val,
    output logic              mdio_o,
    output logic              mdio_oe
);

    localparam int FRAME_W = PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;
    localparam int IDX_W   = $clog2(FRAME_W) + 1;
    localparam logic [IDX_W-1:0] PRE_END  = IDX_W'(PRE_LEN - 1);
    localparam logic [IDX_W-1:0] HDR_END  = IDX_W'(PRE_LEN + 4 + PHY_W + REG_W - 1);
    localparam logic [IDX_W-1:0] TA_END   = IDX_W'(PRE_LEN + 4 + PHY_W + REG_W + 1);
    localparam logic [IDX_W-1:0] DATA_END = IDX_W'(FRAME_W - 1);
    localparam logic [IDX_W-1:0] NO_BIT   = '1;

    mdio_state_e        state_q, state_nx;
    logic [FRAME_W-1:0] shreg_q;
    logic [IDX_W-1:0]   bitcnt_q;
    logic [IDX_W-1:0]   line_idx_q;
    logic               wr_q;
    logic               in_data;

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_nx = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_tick && bitcnt_q == PRE_END)  state_nx = ST_HEADER;
            ST_HEADER:   if (fall_tick && bitcnt_q == HDR_END)  state_nx = ST_TURN;
            ST_TURN:     if (fall_tick && bitcnt_q == TA_END)   state_nx = ST_DATA;
            ST_DATA:     if (fall_tick && bitcnt_q == DATA_END) state_nx = ST_FINISH;
            ST_FINISH:   if (fall_tick) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    assign idle      = (state_q == ST_IDLE);
    assign done      = (state_q == ST_FINISH) && fall_tick;
    assign alive_upd = rise_tick && !wr_q && (line_idx_q == TA_END);
    assign alive_val = ~mdio_i;
    assign in_data   = (line_idx_q > TA_END) && (line_idx_q <= DATA_END);

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            bitcnt_q   <= '0;
            line_idx_q <= NO_BIT;
            wr_q       <= 1'b0;
            rdata      <= '0;
            mdio_o     <= 1'b1;
            mdio_oe    <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) begin
                if (start) begin
                    shreg_q    <= {{PRE_LEN{1'b1}}, 2'b01, (cmd_wr ? 2'b01 : 2'b10),
                                   cmd_phy, cmd_reg, 2'b10, cmd_data};
                    bitcnt_q   <= '0;
                    line_idx_q <= NO_BIT;
                    wr_q       <= cmd_wr;
                end
            end else if (fall_tick) begin
                unique case (state_q)
                    ST_PREAMBLE, ST_HEADER: begin
                        mdio_o  <= shreg_q[FRAME_W-1];
                        mdio_oe <= 1'b1;
                    end
                    ST_TURN, ST_DATA: begin
                        mdio_o  <= shreg_q[FRAME_W-1];
                        mdio_oe <= wr_q;
                    end
                    default: begin
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b0;
                    end
                endcase
                shreg_q    <= {shreg_q[FRAME_W-2:0], 1'b0};
                bitcnt_q   <= bitcnt_q + 1'b1;
                line_idx_q <= (state_q == ST_FINISH) ? NO_BIT : bitcnt_q;
            end
            if (rise_tick && !wr_q && in_data) begin
                rdata <= {rdata[DATA_W-2:0], mdio_i};
            end
        end
    end

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] access_q,
    output logic [31:0] control_q,
    output logic [31:0] alive_q,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic              busy_q, wr_q, en_q;
    logic [REG_W-1:0]  reg_q;
    logic [PHY_W-1:0]  phy_q;
    logic [DATA_W-1:0] data_q;
    logic [DIV_W-1:0]  div_q;
    logic [PHY_N-1:0]  alive_bits;

    logic              acc_wr, start;
    logic              rise_tick, fall_tick;
    logic              eng_idle, eng_done, alive_upd, alive_val;
    logic [DATA_W-1:0] eng_rdata;
    logic              unused_bits;

    assign unused_bits = ^{reg_wdata[29:DIV_W], eng_idle};

    assign acc_wr = reg_we && (reg_sel == SEL_ACCESS) && !busy_q;
    assign start  = acc_wr && reg_wdata[ACC_GO_BIT] && en_q;

    mdio_clkgen #(.DIV_W(DIV_W)) i_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_q),
        .div       (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine #(.PRE_LEN(PRE_LEN)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_wr    (reg_wdata[ACC_WR_BIT]),
        .cmd_phy   (reg_wdata[ACC_PHY_LO +: PHY_W]),
        .cmd_reg   (reg_wdata[ACC_REG_LO +: REG_W]),
        .cmd_data  (reg_wdata[DATA_W-1:0]),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .idle      (eng_idle),
        .done      (eng_done),
        .rdata     (eng_rdata),
        .alive_upd (alive_upd),
        .alive_val (alive_val),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            div_q <= '0;
        end else if (reg_we && reg_sel == SEL_CONTROL) begin
            en_q  <= reg_wdata[CTL_EN_BIT];
            div_q <= reg_wdata[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            wr_q   <= 1'b0;
            reg_q  <= '0;
            phy_q  <= '0;
            data_q <= '0;
        end else if (acc_wr) begin
            busy_q <= start;
            wr_q   <= reg_wdata[ACC_WR_BIT];
            reg_q  <= reg_wdata[ACC_REG_LO +: REG_W];
            phy_q  <= reg_wdata[ACC_PHY_LO +: PHY_W];
            data_q <= reg_wdata[DATA_W-1:0];
        end else if (eng_done) begin
            busy_q <= 1'b0;
            if (!wr_q) data_q <= eng_rdata;
        end
    end

    for (genvar p = 0; p < PHY_N; p++) begin : g_alive
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                alive_bits[p] <= 1'b0;
            else if (alive_upd && phy_q == PHY_W'(p)) alive_bits[p] <= alive_val;
        end
    end

    assign access_q  = {busy_q, wr_q, 4'b0000, reg_q, phy_q, data_q};
    assign control_q = {!busy_q, en_q, {(30-DIV_W){1'b0}}, div_q};
    assign alive_q   = alive_bits;

endmodule

module mdio_mgmt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] access_q,
    input logic [31:0] control_q,
    input logic [31:0] alive_q,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);

    AST_BUSY_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        access_q[31] |-> !control_q[31]); // R1

    AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        control_q[31] |-> !mdio_oe); // R3

    AST_PIN_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R7

    AST_MDC_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !control_q[30] |=> !mdc); // R9

    AST_ALIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !access_q[31] |=> $stable(alive_q)); // R5

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        access_q[31] |=> $stable(access_q[30:16])); // R8

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_checker i_mdio_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .access_q  (access_q),
    .control_q (control_q),
    .alive_q   (alive_q),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] access_q, control_q, alive_q;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    mdio_mgmt_ctrl i_mdio_mgmt_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .access_q(access_q), .control_q(control_q),
        .alive_q(alive_q), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // PHY model
    logic        m_wr = 1'b1, m_present = 1'b0, m_seen = 1'b0;
    logic [15:0] m_resp = '0;
    logic [63:0] cap = '0, oecap = '0;
    int          nrise = 0;

    always @(posedge mdc) begin
        if (access_q[31] && (mdio_oe || m_seen)) begin
            m_seen = 1'b1;
            cap    = {cap[62:0], mdio_o};
            oecap  = {oecap[62:0], mdio_oe};
            nrise  = nrise + 1;
        end
    end

    always @(negedge mdc) begin
        if (!m_wr && m_present && nrise == 47)                     mdio_i = 1'b0;
        else if (!m_wr && m_present && nrise >= 48 && nrise <= 63) mdio_i = m_resp[63-nrise];
        else                                                        mdio_i = 1'b1;
    end

    // R7 monitor: pin changes while MDC stays high
    logic prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b0;
    int   r7_bad = 0;
    always @(negedge clk) begin
        if (rst_n && mdc && prev_mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe))
            r7_bad++;
        prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic prep_model(input logic wr, input logic present, input logic [15:0] resp);
        m_wr = wr; m_present = present; m_resp = resp;
        m_seen = 1'b0; nrise = 0; cap = '0; oecap = '0;
    endtask

    task automatic wait_free();
        for (int n = 0; n < 20000 && access_q[31]; n++) @(negedge clk);
    endtask

    function automatic logic [63:0] frame(input logic wr, input logic [4:0] phy,
                                          input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, d};
    endfunction

    // vector table: {wr, phy, reg, data, present, resp}
    localparam logic [43:0] VEC [6] = '{
        {1'b1, 5'd1,  5'd0,  16'h1200, 1'b0, 16'h0000},
        {1'b0, 5'd1,  5'd2,  16'h0000, 1'b1, 16'h0141},
        {1'b0, 5'd7,  5'd3,  16'h5555, 1'b0, 16'h0000},
        {1'b1, 5'd31, 5'd31, 16'hA5C3, 1'b0, 16'h0000},
        {1'b0, 5'd31, 5'd1,  16'h0000, 1'b1, 16'h8001},
        {1'b0, 5'd1,  5'd2,  16'h0000, 1'b0, 16'h0000}
    };

    task automatic measure_mdc(input int div);
        time t0, t1, t2;
        write_reg(1'b1, {1'b0, 1'b1, 22'd0, 8'(div)});
        repeat (3) @(posedge mdc);
        t0 = $time; @(negedge mdc); t1 = $time; @(posedge mdc); t2 = $time;
        chk((t1 - t0) == time'((div + 1) * CLK_PERIOD), "R6 mdc high time", 64'(t1 - t0), 64'((div + 1) * CLK_PERIOD));
        chk((t2 - t0) == time'(2 * (div + 1) * CLK_PERIOD), "R6 mdc period", 64'(t2 - t0), 64'(2 * (div + 1) * CLK_PERIOD));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] exp_alive;
        exp_alive = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(access_q == 32'h0, "R10 access reset", 64'(access_q), 64'h0);
        chk(control_q == 32'h8000_0000, "R10 control reset", 64'(control_q), 64'h8000_0000);
        chk(alive_q == 32'h0, "R10 alive reset", 64'(alive_q), 64'h0);
        chk(!mdc && !mdio_oe, "R10 pins reset", {62'd0, mdc, mdio_oe}, 64'h0);

        // R9: go while disabled
        write_reg(1'b0, {1'b1, 1'b1, 4'd0, 5'd3, 5'd4, 16'h1234});
        chk(access_q[31] == 1'b0, "R9 go ignored when disabled", 64'(access_q), 64'(32'h4064_1234));
        chk(control_q[31] == 1'b1, "R9 idle while disabled", 64'(control_q), 64'h8000_0000);
        begin
            int hi = 0;
            for (int i = 0; i < 40; i++) begin @(negedge clk); if (mdc) hi++; end
            chk(hi == 0, "R9 mdc parked low", 64'(hi), 64'h0);
        end

        // R10 control layout
        write_reg(1'b1, {1'b0, 1'b1, 22'd0, 8'd1});
        chk(control_q == 32'hC000_0001, "R10 control readback", 64'(control_q), 64'hC000_0001);

        // vector table
        foreach (VEC[i]) begin
            logic        wr, pres;
            logic [4:0]  phy, rg;
            logic [15:0] d, resp;
            {wr, phy, rg, d, pres, resp} = VEC[i];
            prep_model(wr, pres, resp);
            write_reg(1'b0, {1'b1, wr, 4'd0, rg, phy, d});
            chk(access_q[31] && !control_q[31], "R1 busy set, idle clear", 64'({access_q[31], control_q[31]}), 64'h2);
            wait_free();
            chk(control_q[31] == 1'b1, "R1 idle after done", 64'(control_q[31]), 64'h1);
            chk(nrise == 64, "R2 frame length", 64'(nrise), 64'd64);
            if (wr) begin
                chk(cap == frame(1'b1, phy, rg, d), "R2 write frame", cap, frame(1'b1, phy, rg, d));
                chk(oecap == '1, "R2 write drives all bits", oecap, '1);
                chk(access_q == {1'b0, 1'b1, 4'd0, rg, phy, d}, "R4 write keeps fields", 64'(access_q), 64'({1'b0, 1'b1, 4'd0, rg, phy, d}));
                chk(alive_q == exp_alive, "R5 write leaves alive", 64'(alive_q), 64'(exp_alive));
            end else begin
                chk(cap[63:18] == frame(1'b0, phy, rg, d) >> 18, "R3 read header", 64'(cap[63:18]), frame(1'b0, phy, rg, d) >> 18);
                chk(oecap == {{46{1'b1}}, 18'd0}, "R3 read releases line", oecap, {{46{1'b1}}, 18'd0});
                chk(access_q == {1'b0, 1'b0, 4'd0, rg, phy, (pres ? resp : 16'hFFFF)}, "R4 read data",
                    64'(access_q), 64'({1'b0, 1'b0, 4'd0, rg, phy, (pres ? resp : 16'hFFFF)}));
                exp_alive[phy] = pres;
                chk(alive_q == exp_alive, "R5 alive bit", 64'(alive_q), 64'(exp_alive));
            end
        end

        // R8: write while busy is ignored
        prep_model(1'b1, 1'b0, 16'h0);
        write_reg(1'b0, {1'b1, 1'b1, 4'd0, 5'd4, 5'd2, 16'h1111});
        repeat (20) @(negedge clk);
        write_reg(1'b0, {1'b1, 1'b0, 4'd0, 5'd9, 5'd9, 16'hFFFF});
        wait_free();
        chk(cap == frame(1'b1, 5'd2, 5'd4, 16'h1111), "R8 frame unaffected", cap, frame(1'b1, 5'd2, 5'd4, 16'h1111));
        chk(access_q == {1'b0, 1'b1, 4'd0, 5'd4, 5'd2, 16'h1111}, "R8 fields unaffected",
            64'(access_q), 64'({1'b0, 1'b1, 4'd0, 5'd4, 5'd2, 16'h1111}));

        // R6 divider settings
        measure_mdc(0);
        measure_mdc(3);
        measure_mdc(9);

        // R7 one read at div 0 then summary of monitor
        write_reg(1'b1, {1'b0, 1'b1, 22'd0, 8'd0});
        prep_model(1'b0, 1'b1, 16'h7E81);
        write_reg(1'b0, {1'b1, 1'b0, 4'd0, 5'd5, 5'd6, 16'h0});
        wait_free();
        chk(access_q[15:0] == 16'h7E81, "R7 sampling at div 0", 64'(access_q[15:0]), 64'h7E81);
        chk(r7_bad == 0, "R7 pin changes only on MDC fall", 64'(r7_bad), 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule